// File: doc/BRIEF.md
# Dark-Row Black Level Corrector

This block sits in a raw pixel stream straight behind an image sensor and removes the black offset that drifts over time. The sensor sends a band of optically shielded rows in every frame. A register picks where that band starts and how many rows it spans. While those rows pass, the block sums pixel values into four separate accumulators, one for each Bayer colour site: red, first green, second green and blue. Each accumulator takes only the first 2^L pixels of its site, where L is a register. At the next frame start, every accumulator that is full turns its sum into a new offset by shifting it right by L.

On the remaining rows each pixel has the offset of its own colour site subtracted. A result that would go below zero is held at zero. The shielded rows are removed from the output stream. The frame-start and line-start markers are rebuilt so that the downstream stream begins at the first visible row. A mode bit sends every pixel through a single channel for monochrome sensors, and a two-bit phase register selects which site sits at the top-left corner.

Top module: `dark_row_black_level`

## Requirements
- R1: During and after reset all outputs are 0 and all four offsets are 0, so pixels of the first frame pass through unchanged.
- R2: A pixel at row r, column c belongs to channel index {r[0]^phase[1], c[0]^phase[0]}, where index 0 is red, 1 is first green, 2 is second green and 3 is blue.
- R3: The offset of a channel is the sum of the first 2^L dark-row pixels of that channel in a frame, shifted right by L. The new offset applies from the frame-start pixel of the next frame onward, including that pixel itself.
- R4: A channel that collected fewer than 2^L dark pixels in the previous frame keeps its earlier offset at frame start.
- R5: An emitted pixel equals in_pix minus the offset of its channel, or 0 when the offset is larger than in_pix.
- R6: Rows whose index lies in [dark_first, dark_first+dark_count) produce no output (out_valid stays 0). Row 0 is the row carrying in_fsync, and each in_lsync starts the next row.
- R7: out_fsync is 1 on the first emitted pixel after an input frame start. out_lsync is 1 on every emitted pixel that is at column 0.
- R8: With cfg_mono set, every pixel uses channel 0 for both accumulation and correction.
- R9: Outputs appear one clock after the input pixel, and a cycle with in_valid low produces out_valid low on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_dark_first | input | ROW_W | Index of the first shielded row |
| cfg_dark_count | input | ROW_W | Number of shielded rows |
| cfg_avg_log2 | input | L_W | Log2 of the pixels averaged per channel (limited to MAX_L) |
| cfg_bayer_phase | input | 2 | Row/column parity flip for the channel map |
| cfg_mono | input | 1 | Single-channel mode |
| in_valid | input | 1 | Input pixel qualifier |
| in_fsync | input | 1 | Marks the first pixel of a frame |
| in_lsync | input | 1 | Marks the first pixel of a line |
| in_pix | input | PIX_W | Raw pixel value |
| out_valid | output | 1 | Corrected pixel qualifier |
| out_fsync | output | 1 | First emitted pixel of a frame |
| out_lsync | output | 1 | First emitted pixel of a line |
| out_pix | output | PIX_W | Corrected pixel value |

## Verification
The bench builds the block with PIX_W=8, MAX_L=4 and 6-bit row and column counters. With 8-bit pixels and dark values below 64, the floor at zero in R5 is reached often. The bench uses an 8x8 frame, so every parity of row and column appears, and the shielded band can be moved to the top, the middle or the bottom of the frame. With a small L, the per-channel limit can be set both above and below the number of dark pixels a channel actually receives, which drives both the update case of R3 and the hold case of R4.

// File: rtl/dblc_pkg.sv
package dblc_pkg;
  localparam int unsigned NUM_CH = 4;

  typedef enum logic [1:0] {
    CH_RED   = 2'd0,
    CH_GRN_A = 2'd1,
    CH_GRN_B = 2'd2,
    CH_BLUE  = 2'd3
  } chan_e;

  // Colour site of a pixel from its row/column parity (R2, R8)
  function automatic chan_e chan_of(input logic row_odd, input logic col_odd,
                                    input logic [1:0] phase, input logic mono);
    if (mono) return CH_RED;
    return chan_e'({row_odd ^ phase[1], col_odd ^ phase[0]});
  endfunction
endpackage

// File: rtl/dblc_pos_track.sv
module dblc_pos_track #(
  parameter int unsigned ROW_W = 12,
  parameter int unsigned COL_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_fsync,
  input  logic             in_lsync,
  input  logic [ROW_W-1:0] cfg_dark_first,
  input  logic [ROW_W-1:0] cfg_dark_count,
  output logic [ROW_W-1:0] row_cur,
  output logic [COL_W-1:0] col_cur,
  output logic             dark_row,
  output logic             emit_fs,
  output logic             emit_ls
);
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic             fs_pend_q;
  logic [ROW_W:0]   dark_end;
  logic             keep;

  always_comb begin
    if (in_fsync) begin
      row_cur = '0;
      col_cur = '0;
    end else if (in_lsync) begin
      row_cur = row_q + ROW_W'(1);
      col_cur = '0;
    end else begin
      row_cur = row_q;
      col_cur = col_q + COL_W'(1);
    end
  end

  assign dark_end = {1'b0, cfg_dark_first} + {1'b0, cfg_dark_count};
  assign dark_row = (row_cur >= cfg_dark_first) && ({1'b0, row_cur} < dark_end);
  assign keep     = in_valid && !dark_row;
  assign emit_fs  = keep && (in_fsync || fs_pend_q);
  assign emit_ls  = keep && (col_cur == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q     <= '0;
      col_q     <= '0;
      fs_pend_q <= 1'b0;
    end else if (in_valid) begin
      row_q     <= row_cur;
      col_q     <= col_cur;
      fs_pend_q <= (in_fsync || fs_pend_q) && dark_row;
    end
  end
endmodule

// File: rtl/dblc_chan_acc.sv
module dblc_chan_acc #(
  parameter int unsigned PIX_W = 12,
  parameter int unsigned MAX_L = 10,
  parameter int unsigned L_W   = $clog2(MAX_L + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic             hit,
  input  logic [PIX_W-1:0] pix,
  input  logic [L_W-1:0]   shift,
  output logic [PIX_W-1:0] off_eff
);
  localparam int unsigned ACC_W = PIX_W + MAX_L;
  localparam int unsigned CNT_W = MAX_L + 1;

  logic [ACC_W-1:0] acc_q, acc_base;
  logic [CNT_W-1:0] cnt_q, cnt_base, lim;
  logic [PIX_W-1:0] off_q;
  logic             full, take;

  assign lim      = CNT_W'(1) << shift;
  assign full     = (cnt_q == lim);
  assign off_eff  = (frame_start && full) ? PIX_W'(acc_q >> shift) : off_q;
  assign acc_base = frame_start ? '0 : acc_q;
  assign cnt_base = frame_start ? '0 : cnt_q;
  assign take     = hit && (cnt_base < lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      cnt_q <= '0;
      off_q <= '0;
    end else begin
      off_q <= off_eff;
      if (frame_start || take) begin
        acc_q <= acc_base + (take ? ACC_W'(pix) : '0);
        cnt_q <= cnt_base + CNT_W'(take);
      end
    end
  end
endmodule

// File: rtl/dark_row_black_level.sv
module dark_row_black_level #(
  parameter int unsigned PIX_W = 12,
  parameter int unsigned ROW_W = 12,
  parameter int unsigned COL_W = 12,
  parameter int unsigned MAX_L = 10,
  parameter int unsigned L_W   = $clog2(MAX_L + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ROW_W-1:0] cfg_dark_first,
  input  logic [ROW_W-1:0] cfg_dark_count,
  input  logic [L_W-1:0]   cfg_avg_log2,
  input  logic [1:0]       cfg_bayer_phase,
  input  logic             cfg_mono,
  input  logic             in_valid,
  input  logic             in_fsync,
  input  logic             in_lsync,
  input  logic [PIX_W-1:0] in_pix,
  output logic             out_valid,
  output logic             out_fsync,
  output logic             out_lsync,
  output logic [PIX_W-1:0] out_pix
);
  import dblc_pkg::*;

  function automatic logic [PIX_W-1:0] sub_floor(input logic [PIX_W-1:0] a,
                                                 input logic [PIX_W-1:0] b);
    return (a > b) ? (a - b) : '0;
  endfunction

  logic [ROW_W-1:0] row_cur;
  logic [COL_W-1:0] col_cur;
  logic             dark_row_w;
  logic             emit_fs_w, emit_ls_w;
  logic             frame_start_w;
  logic [L_W-1:0]   shift_w;
  chan_e            chan_w;
  logic [PIX_W-1:0] off_eff [NUM_CH];
  logic [PIX_W-1:0] off_sel;

  dblc_pos_track #(.ROW_W(ROW_W), .COL_W(COL_W)) u_pos (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_fsync(in_fsync),
    .in_lsync(in_lsync), .cfg_dark_first(cfg_dark_first),
    .cfg_dark_count(cfg_dark_count), .row_cur(row_cur), .col_cur(col_cur),
    .dark_row(dark_row_w), .emit_fs(emit_fs_w), .emit_ls(emit_ls_w)
  );

  assign frame_start_w = in_valid && in_fsync;
  assign shift_w = (cfg_avg_log2 > L_W'(MAX_L)) ? L_W'(MAX_L) : cfg_avg_log2;
  assign chan_w  = chan_of(row_cur[0], col_cur[0], cfg_bayer_phase, cfg_mono);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    logic hit;
    assign hit = in_valid && dark_row_w && (chan_w == chan_e'(g));
    dblc_chan_acc #(.PIX_W(PIX_W), .MAX_L(MAX_L), .L_W(L_W)) u_acc (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start_w), .hit(hit),
      .pix(in_pix), .shift(shift_w), .off_eff(off_eff[g])
    );
  end

  assign off_sel = off_eff[chan_w];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_fsync <= 1'b0;
      out_lsync <= 1'b0;
      out_pix   <= '0;
    end else begin
      out_valid <= in_valid && !dark_row_w;
      out_fsync <= emit_fs_w;
      out_lsync <= emit_ls_w;
      out_pix   <= (in_valid && !dark_row_w) ? sub_floor(in_pix, off_sel) : '0;
    end
  end
endmodule

// File: rtl/dblc_chk.sv
module dblc_chk #(
  parameter int unsigned PIX_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [PIX_W-1:0] in_pix,
  input logic             dark_now,
  input logic             out_valid,
  input logic             out_fsync,
  input logic             out_lsync,
  input logic [PIX_W-1:0] out_pix
);
  // R9
  idle_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R6
  dark_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && dark_now) |=> !out_valid);
  // R7
  fsync_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_fsync |-> (out_valid && out_lsync));
  // R7
  lsync_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_lsync |-> out_valid);
  // R5
  never_above_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_pix <= $past(in_pix)));
endmodule

bind dark_row_black_level dblc_chk #(.PIX_W(PIX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pix(in_pix),
  .dark_now(dark_row_w), .out_valid(out_valid), .out_fsync(out_fsync),
  .out_lsync(out_lsync), .out_pix(out_pix)
);

// File: tb/dark_row_black_level_tb_top.sv
module dark_row_black_level_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PIX_W = 8;
  localparam int ROW_W = 6;
  localparam int COL_W = 6;
  localparam int MAX_L = 4;
  localparam int L_W   = $clog2(MAX_L + 1);
  localparam int ROWS  = 8;
  localparam int COLS  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [ROW_W-1:0] cfg_dark_first = 6'd2;
  logic [ROW_W-1:0] cfg_dark_count = 6'd2;
  logic [L_W-1:0]   cfg_avg_log2 = 3'd2;
  logic [1:0]       cfg_bayer_phase = 2'b00;
  logic             cfg_mono = 1'b0;
  logic             in_valid = 1'b0, in_fsync = 1'b0, in_lsync = 1'b0;
  logic [PIX_W-1:0] in_pix = '0;
  logic             out_valid, out_fsync, out_lsync;
  logic [PIX_W-1:0] out_pix;

  int checks = 0;
  int errors = 0;
  int unsigned boff [4];
  int unsigned bacc [4];
  int unsigned bcnt [4];
  bit fs_pend = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dark_row_black_level #(.PIX_W(PIX_W), .ROW_W(ROW_W), .COL_W(COL_W),
                         .MAX_L(MAX_L)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_dark_first(cfg_dark_first),
    .cfg_dark_count(cfg_dark_count), .cfg_avg_log2(cfg_avg_log2),
    .cfg_bayer_phase(cfg_bayer_phase), .cfg_mono(cfg_mono),
    .in_valid(in_valid), .in_fsync(in_fsync), .in_lsync(in_lsync),
    .in_pix(in_pix), .out_valid(out_valid), .out_fsync(out_fsync),
    .out_lsync(out_lsync), .out_pix(out_pix)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Bench view of the colour map: red=0, green1=1, green2=2, blue=3
  function automatic int site_of(input int r, input int c);
    int rb, cb;
    if (cfg_mono) return 0;
    rb = (r % 2) ^ int'(cfg_bayer_phase[1]);
    cb = (c % 2) ^ int'(cfg_bayer_phase[0]);
    return rb * 2 + cb;
  endfunction

  function automatic int floor_sub(input int a, input int b);
    return (a > b) ? a - b : 0;
  endfunction

  function automatic int eff_l();
    return (int'(cfg_avg_log2) > MAX_L) ? MAX_L : int'(cfg_avg_log2);
  endfunction

  task automatic idle_cycle(input string tag);
    @(negedge clk);
    in_valid = 1'b0; in_fsync = 1'b0; in_lsync = 1'b0;
    @(posedge clk); #1;
    chk(out_valid == 1'b0, {tag, " R9"}, "idle out_valid", int'(out_valid), 0);
    chk(out_fsync == 1'b0, {tag, " R7"}, "idle out_fsync", int'(out_fsync), 0);
  endtask

  task automatic drive_pixel(input int r, input int c, input int pix, input string tag);
    bit dark, ev, efs, els;
    int ch, ep, lim;
    @(negedge clk);
    lim = 1 << eff_l();
    if (r == 0 && c == 0) begin
      for (int k = 0; k < 4; k++) begin
        if (bcnt[k] == lim) boff[k] = bacc[k] >> eff_l();
        bacc[k] = 0;
        bcnt[k] = 0;
      end
    end
    dark = (r >= int'(cfg_dark_first)) && (r < int'(cfg_dark_first) + int'(cfg_dark_count));
    ch   = site_of(r, c);
    ev   = !dark;
    ep   = floor_sub(pix, boff[ch]);
    efs  = ev && (fs_pend || (r == 0 && c == 0));
    els  = ev && (c == 0);
    if (r == 0 && c == 0) fs_pend = 1;
    if (ev) fs_pend = 0;
    if (dark && bcnt[ch] < lim) begin
      bacc[ch] += pix;
      bcnt[ch]++;
    end
    in_valid = 1'b1;
    in_fsync = (r == 0 && c == 0);
    in_lsync = (c == 0);
    in_pix   = PIX_W'(pix);
    @(posedge clk); #1;
    chk(out_valid == ev, {tag, " R6 R9"}, "out_valid", int'(out_valid), int'(ev));
    chk(out_fsync == efs, {tag, " R7"}, "out_fsync", int'(out_fsync), int'(efs));
    chk(out_lsync == els, {tag, " R7"}, "out_lsync", int'(out_lsync), int'(els));
    if (ev) chk(int'(out_pix) == ep, {tag, " R5 R2"}, "out_pix", int'(out_pix), ep);
  endtask

  task automatic run_frame(input int gap_pct, input string tag);
    int pix;
    for (int r = 0; r < ROWS; r++) begin
      for (int c = 0; c < COLS; c++) begin
        if (int'($urandom % 100) < gap_pct) idle_cycle(tag);
        if ((r >= int'(cfg_dark_first)) && (r < int'(cfg_dark_first) + int'(cfg_dark_count)))
          pix = int'($urandom % 64);
        else if ($urandom % 8 == 0)
          pix = int'($urandom % 16);
        else
          pix = int'($urandom % 256);
        drive_pixel(r, c, pix, tag);
      end
    end
    idle_cycle(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=expired expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int k = 0; k < 4; k++) begin
      boff[k] = 0; bacc[k] = 0; bcnt[k] = 0;
    end
    repeat (3) @(posedge clk);
    #1;
    chk(out_valid == 1'b0, "R1", "reset out_valid", int'(out_valid), 0);
    chk(out_pix == '0, "R1", "reset out_pix", int'(out_pix), 0);
    chk(out_fsync == 1'b0 && out_lsync == 1'b0, "R1", "reset syncs",
        int'({out_fsync, out_lsync}), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // First frame: offsets still zero, pixels pass unchanged
    run_frame(0, "R1");
    // Random frames with gaps, band in the middle
    for (int f = 0; f < 3; f++) run_frame(20, "R3");
    // Every phase of the colour map
    cfg_bayer_phase = 2'b01; run_frame(10, "R2 R3");
    cfg_bayer_phase = 2'b10; run_frame(10, "R2 R3");
    cfg_bayer_phase = 2'b11; run_frame(10, "R2 R3");
    cfg_bayer_phase = 2'b00; run_frame(0, "R3");
    // Limit above what a channel receives: offsets must hold
    cfg_avg_log2 = 3'd3; run_frame(0, "R4");
    run_frame(0, "R4");
    // Taller band fills the larger limit
    cfg_dark_count = 6'd4; run_frame(0, "R3");
    run_frame(0, "R3");
    // Single pixel per channel
    cfg_avg_log2 = 3'd0; cfg_dark_count = 6'd2; run_frame(5, "R3");
    run_frame(5, "R3");
    // Band at the top: frame start marker must move to row 2
    cfg_avg_log2 = 3'd2; cfg_dark_first = 6'd0; run_frame(0, "R7");
    run_frame(0, "R7");
    // Band at the bottom
    cfg_dark_first = 6'd6; run_frame(10, "R6");
    run_frame(10, "R6");
    // Monochrome: a single channel for everything
    cfg_mono = 1'b1; cfg_dark_first = 6'd3; run_frame(0, "R8");
    run_frame(15, "R8");
    run_frame(0, "R8");
    cfg_mono = 1'b0; run_frame(0, "R2 R3");
    run_frame(0, "R3");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule